// File: doc/BRIEF.md
# Cell Delineation Loss Persistence Timer

This block supervises cell delineation for a group of receive ports. Each port reports one delineation status bit: high while the port is in the synchronised state, low while it is out of delineation. For each port the block keeps a maintenance state, either Working or Loss. It moves between the two only after a status change has lasted a programmable number of timebase ticks. The same per-port timer qualifies both directions. Entering Loss raises a start interrupt pulse and returning to Working raises an end interrupt pulse.

All ports share one enable and one preload value. The tick input is normally a one-millisecond strobe, so a preload of 50 gives the recommended persistence. The block also turns a per-port software go-hunt control into a one-cycle hunt request toward that port's delineation machine. The delineation machine, the register bus and the interrupt status registers are outside this block.

Top module: `cdl_supervisor`

## Requirements
- R1: During and after synchronous reset, `loss_state`, `irq_start`, `irq_end` and `force_hunt` are all zero and every port is in Working (loss bit 0).
- R2: With `enable` high, a port in Working whose `sync_in` bit goes from 1 to 0 starts its timer. If the bit stays 0 until expiry, the port's `loss_state` bit becomes 1 and its `irq_start` bit pulses high for one cycle, both on the clock edge that samples the expiring tick.
- R3: If a Working port's `sync_in` returns to 1 before its timer expires, the timer is abandoned. The port stays in Working and no interrupt is raised.
- R4: A port in Loss whose `sync_in` goes from 0 to 1 starts its timer. On expiry with `sync_in` still 1, `loss_state` clears to 0 and `irq_end` pulses for one cycle on the same edge.
- R5: If `sync_in` drops to 0 while the recovery timer runs, the port stays in Loss and the timer is cleared. A later 0-to-1 change must then wait a full preload again.
- R6: The timer is loaded from `preload` when it starts, so later changes to `preload` do not affect a running timer. Expiry happens on the preload-th `tick` after the start cycle. A tick in the start cycle itself is not counted, and a preload of 0 behaves as 1.
- R7: While `enable` is low, every port returns to Working on the next edge and all timers are cleared. No interrupt is raised, and status changes that happen while disabled start nothing.
- R8: Ports are independent: one port's status, timer and state never affect another port's outputs.
- R9: A 0-to-1 change of a `go_hunt` bit gives exactly one one-cycle pulse on the same `force_hunt` bit on the next edge, whatever `enable` is. Holding `go_hunt` high gives no further pulses.
- R10: `irq_start` and `irq_end` are single-cycle pulses and are never high together for the same port.
- R11: The preload field is wide enough for at least 50 ticks. A preload of 50 expires on exactly the 50th tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable for all persistence timers |
| preload | input | TMR_W (16) | Shared timer preload in ticks |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| sync_in | input | NUM_PORTS | Per-port delineation status, 1 = synchronised |
| go_hunt | input | NUM_PORTS | Per-port software hunt control |
| loss_state | output | NUM_PORTS | Per-port maintenance state, 1 = Loss |
| irq_start | output | NUM_PORTS | One-cycle pulse on entry into Loss |
| irq_end | output | NUM_PORTS | One-cycle pulse on return to Working |
| force_hunt | output | NUM_PORTS | One-cycle hunt request |

## Verification
The bench aims at the exact tick of expiry. A timer that is off by one would assert Loss a tick early or late, and one that counts the tick arriving in the start cycle would expire one tick early. It aborts the recovery timer partway through and then regains sync. A design that only pauses the timer, instead of clearing it, would leave Loss too soon. It also drops the enable while a port is in Loss and wiggles the status while disabled. A design that keeps its state across disable, or that acts on edges seen while disabled, would show a stale Loss bit or a spurious interrupt. Finally, a long constrained-random run with independent per-port status changes exposes any coupling between ports.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

    typedef enum logic {
        MS_WORKING = 1'b0,
        MS_LOSS    = 1'b1
    } maint_e;

    // Status level that cancels a running timer in a given state
    function automatic logic timer_abort(input maint_e mode, input logic sync_now);
        return (mode == MS_WORKING) ? sync_now : !sync_now;
    endfunction

    // Edge that arms a timer in a given state
    function automatic logic timer_arm(input maint_e mode, input logic rise, input logic fall);
        return (mode == MS_WORKING) ? fall : rise;
    endfunction

    // True when the tick being consumed is the final one
    function automatic logic last_tick(input int unsigned remaining);
        return remaining <= 1;
    endfunction

endpackage

// File: rtl/cdl_edge_det.sv
module cdl_edge_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;
    assign fall = prev_q & ~din;
endmodule

// File: rtl/cdl_hunt_pulse.sv
module cdl_hunt_pulse #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] req,
    output logic [W-1:0] pulse
);
    logic [W-1:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pulse <= '0;
        end else begin
            req_q <= req;
            pulse <= req & ~req_q;
        end
    end
endmodule

// File: rtl/cdl_port_timer.sv
module cdl_port_timer
    import cdl_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic [TMR_W-1:0] preload,
    input  logic             sync_now,
    input  logic             sync_rise,
    input  logic             sync_fall,
    output logic             loss,
    output logic             pulse_start,
    output logic             pulse_end
);
    typedef struct packed {
        maint_e           mode;
        logic             running;
        logic [TMR_W-1:0] remaining;
    } tmr_state_t;

    tmr_state_t cur_q, nxt;
    logic       nxt_start, nxt_end;

    always_comb begin
        nxt       = cur_q;
        nxt_start = 1'b0;
        nxt_end   = 1'b0;
        if (!enable) begin
            nxt.mode      = MS_WORKING;
            nxt.running   = 1'b0;
            nxt.remaining = '0;
        end else if (!cur_q.running) begin
            if (timer_arm(cur_q.mode, sync_rise, sync_fall)) begin
                nxt.running   = 1'b1;
                nxt.remaining = preload;
            end
        end else if (timer_abort(cur_q.mode, sync_now)) begin
            nxt.running   = 1'b0;
            nxt.remaining = '0;
        end else if (tick) begin
            if (last_tick(int'(cur_q.remaining))) begin
                nxt.running   = 1'b0;
                nxt.remaining = '0;
                if (cur_q.mode == MS_WORKING) begin
                    nxt.mode  = MS_LOSS;
                    nxt_start = 1'b1;
                end else begin
                    nxt.mode  = MS_WORKING;
                    nxt_end   = 1'b1;
                end
            end else begin
                nxt.remaining = cur_q.remaining - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= '{mode: MS_WORKING, running: 1'b0, remaining: '0};
            pulse_start <= 1'b0;
            pulse_end   <= 1'b0;
        end else begin
            cur_q       <= nxt;
            pulse_start <= nxt_start;
            pulse_end   <= nxt_end;
        end
    end

    assign loss = (cur_q.mode == MS_LOSS);
endmodule

// File: rtl/cdl_supervisor.sv
module cdl_supervisor #(
    parameter int  NUM_PORTS = 4,
    parameter int  MAX_TICKS = 65535,
    localparam int TMR_W     = $clog2(MAX_TICKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [TMR_W-1:0]     preload,
    input  logic                 tick,
    input  logic [NUM_PORTS-1:0] sync_in,
    input  logic [NUM_PORTS-1:0] go_hunt,
    output logic [NUM_PORTS-1:0] loss_state,
    output logic [NUM_PORTS-1:0] irq_start,
    output logic [NUM_PORTS-1:0] irq_end,
    output logic [NUM_PORTS-1:0] force_hunt
);
    logic [NUM_PORTS-1:0] sync_rise, sync_fall;

    cdl_edge_det #(.W(NUM_PORTS)) u_sync_edges (
        .clk  (clk),
        .rst  (rst),
        .din  (sync_in),
        .rise (sync_rise),
        .fall (sync_fall)
    );

    cdl_hunt_pulse #(.W(NUM_PORTS)) u_hunt (
        .clk   (clk),
        .rst   (rst),
        .req   (go_hunt),
        .pulse (force_hunt)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        cdl_port_timer #(.TMR_W(TMR_W)) u_timer (
            .clk         (clk),
            .rst         (rst),
            .enable      (enable),
            .tick        (tick),
            .preload     (preload),
            .sync_now    (sync_in[p]),
            .sync_rise   (sync_rise[p]),
            .sync_fall   (sync_fall[p]),
            .loss        (loss_state[p]),
            .pulse_start (irq_start[p]),
            .pulse_end   (irq_end[p])
        );
    end
endmodule

// File: rtl/cdl_supervisor_chk.sv
module cdl_supervisor_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 enable,
    input logic [NUM_PORTS-1:0] go_hunt,
    input logic [NUM_PORTS-1:0] loss_state,
    input logic [NUM_PORTS-1:0] irq_start,
    input logic [NUM_PORTS-1:0] irq_end,
    input logic [NUM_PORTS-1:0] force_hunt
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        p_start_enters_loss_r2: assert property (@(posedge clk) disable iff (rst)
            irq_start[p] |-> (loss_state[p] && !$past(loss_state[p])));

        p_loss_rise_has_irq_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(loss_state[p]) |-> irq_start[p]);

        p_end_leaves_loss_r4: assert property (@(posedge clk) disable iff (rst)
            irq_end[p] |-> (!loss_state[p] && $past(loss_state[p])));

        p_loss_fall_cause_r7: assert property (@(posedge clk) disable iff (rst)
            $fell(loss_state[p]) |-> (irq_end[p] || !$past(enable)));

        p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
            !$past(enable) |-> (!loss_state[p] && !irq_start[p] && !irq_end[p]));

        p_irq_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
            !(irq_start[p] && irq_end[p]));

        p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
            irq_start[p] |=> !irq_start[p]);

        p_hunt_single_r9: assert property (@(posedge clk) disable iff (rst)
            force_hunt[p] |=> !force_hunt[p]);

        p_hunt_from_edge_r9: assert property (@(posedge clk) disable iff (rst)
            force_hunt[p] |-> $past(go_hunt[p]));
    end
endmodule

bind cdl_supervisor cdl_supervisor_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .go_hunt    (go_hunt),
    .loss_state (loss_state),
    .irq_start  (irq_start),
    .irq_end    (irq_end),
    .force_hunt (force_hunt)
);

// File: tb/cdl_supervisor_test.sv
module cdl_supervisor_test;
    localparam int NP = 4;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          enable;
    logic [TW-1:0] preload;
    logic          tick;
    logic [NP-1:0] sync_in;
    logic [NP-1:0] go_hunt;
    logic [NP-1:0] loss_state, irq_start, irq_end, force_hunt;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    string phase = "R1";

    int start_seen [NP];
    int end_seen   [NP];

    // reference model state
    bit m_loss [NP];
    bit m_run  [NP];
    int m_cnt  [NP];
    bit m_sp   [NP];
    bit m_gp   [NP];
    bit m_es   [NP];
    bit m_ee   [NP];
    bit m_hunt [NP];

    cdl_supervisor #(.NUM_PORTS(NP), .MAX_TICKS(65535)) uut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .preload    (preload),
        .tick       (tick),
        .sync_in    (sync_in),
        .go_hunt    (go_hunt),
        .loss_state (loss_state),
        .irq_start  (irq_start),
        .irq_end    (irq_end),
        .force_hunt (force_hunt)
    );

    always #10 clk = ~clk;

    // Model built from the requirements
    always @(posedge clk) begin
        for (int i = 0; i < NP; i++) begin
            bit rise, fall;
            if (rst) begin
                m_loss[i] = 0; m_run[i] = 0; m_cnt[i] = 0; m_sp[i] = 0;
                m_gp[i] = 0; m_es[i] = 0; m_ee[i] = 0; m_hunt[i] = 0;
            end else begin
                rise = sync_in[i] && !m_sp[i];
                fall = !sync_in[i] && m_sp[i];
                m_hunt[i] = go_hunt[i] && !m_gp[i];
                m_es[i] = 0; m_ee[i] = 0;
                if (!enable) begin
                    m_loss[i] = 0; m_run[i] = 0;
                end else if (!m_run[i]) begin
                    if ((!m_loss[i] && fall) || (m_loss[i] && rise)) begin
                        m_run[i] = 1; m_cnt[i] = int'(preload);
                    end
                end else if (m_loss[i] ? !sync_in[i] : sync_in[i]) begin
                    m_run[i] = 0;
                end else if (tick) begin
                    if (m_cnt[i] <= 1) begin
                        m_run[i] = 0;
                        if (m_loss[i]) m_ee[i] = 1; else m_es[i] = 1;
                        m_loss[i] = !m_loss[i];
                    end else begin
                        m_cnt[i] = m_cnt[i] - 1;
                    end
                end
                m_sp[i] = sync_in[i];
                m_gp[i] = go_hunt[i];
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pack_bits(input bit b [NP]);
        int v = 0;
        for (int i = 0; i < NP; i++) v |= (int'(b[i]) << i);
        return v;
    endfunction

    task automatic cyc();
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            start_seen[i] += int'(irq_start[i]);
            end_seen[i]   += int'(irq_end[i]);
        end
        if (!rst) begin
            chk({phase, " loss_state"}, int'(loss_state), pack_bits(m_loss));
            chk({phase, " irq_start"},  int'(irq_start),  pack_bits(m_es));
            chk({phase, " irq_end"},    int'(irq_end),    pack_bits(m_ee));
            chk({phase, " force_hunt"}, int'(force_hunt), pack_bits(m_hunt));
            chk("R10 irq overlap", int'(irq_start & irq_end), 0);
        end
    endtask

    task automatic tk();
        tick = 1'b1; cyc();
        tick = 1'b0; cyc();
    endtask

    task automatic ntk(int n);
        for (int k = 0; k < n; k++) tk();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int s0, e0;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < NP; i++) begin start_seen[i] = 0; end_seen[i] = 0; end
        rst = 1'b1; enable = 1'b1; preload = 16'd3; tick = 1'b0;
        sync_in = '1; go_hunt = '0;
        repeat (3) cyc();
        phase = "R1";
        chk("R1 loss_state", int'(loss_state), 0);
        chk("R1 irq_start",  int'(irq_start),  0);
        chk("R1 irq_end",    int'(irq_end),    0);
        chk("R1 force_hunt", int'(force_hunt), 0);
        rst = 1'b0;
        repeat (3) cyc();
        chk("R1 after reset", int'(loss_state), 0);

        // R2: entry into Loss after 3 ticks; preload change mid-run ignored (R6)
        phase = "R2";
        s0 = start_seen[0];
        sync_in[0] = 1'b0; cyc();
        preload = 16'd10;
        ntk(2);
        chk("R2 no loss before expiry", int'(loss_state[0]), 0);
        tk();
        chk("R2 loss after third tick", int'(loss_state[0]), 1);
        chk("R2 one start pulse", start_seen[0] - s0, 1);
        chk("R8 other ports untouched", int'(loss_state[3:1]), 0);
        preload = 16'd3;

        // R3: sync regained before expiry
        phase = "R3";
        s0 = start_seen[1];
        sync_in[1] = 1'b0; cyc();
        ntk(2);
        sync_in[1] = 1'b1; cyc();
        ntk(4);
        chk("R3 stays working", int'(loss_state[1]), 0);
        chk("R3 no start irq", start_seen[1] - s0, 0);

        // R4: recovery of port 0
        phase = "R4";
        e0 = end_seen[0];
        sync_in[0] = 1'b1; cyc();
        ntk(2);
        chk("R4 still loss", int'(loss_state[0]), 1);
        tk();
        chk("R4 back to working", int'(loss_state[0]), 0);
        chk("R4 one end pulse", end_seen[0] - e0, 1);

        // R5: recovery aborted and restarted
        phase = "R5";
        sync_in[0] = 1'b0; cyc();
        ntk(3);
        chk("R5 loss entered", int'(loss_state[0]), 1);
        e0 = end_seen[0];
        sync_in[0] = 1'b1; cyc();
        ntk(2);
        sync_in[0] = 1'b0; cyc();
        chk("R5 loss kept on abort", int'(loss_state[0]), 1);
        sync_in[0] = 1'b1; cyc();
        ntk(2);
        chk("R5 timer was cleared", int'(loss_state[0]), 1);
        tk();
        chk("R5 recovery completes", int'(loss_state[0]), 0);
        chk("R5 single end pulse", end_seen[0] - e0, 1);

        // R6: preload 0 acts as 1, tick in start cycle not counted
        phase = "R6";
        preload = 16'd0;
        sync_in[1] = 1'b0; tick = 1'b1; cyc();
        tick = 1'b0; cyc();
        chk("R6 start-cycle tick ignored", int'(loss_state[1]), 0);
        tk();
        chk("R6 preload zero expires on one tick", int'(loss_state[1]), 1);
        sync_in[1] = 1'b1; cyc();
        tk();
        chk("R6 recovery with preload zero", int'(loss_state[1]), 0);
        preload = 16'd3;

        // R7: disable clears Loss silently, edges while off ignored
        phase = "R7";
        sync_in[2] = 1'b0; cyc();
        ntk(3);
        chk("R7 loss before disable", int'(loss_state[2]), 1);
        e0 = end_seen[2];
        s0 = start_seen[2];
        enable = 1'b0; cyc();
        chk("R7 loss cleared on disable", int'(loss_state[2]), 0);
        sync_in[2] = 1'b1; cyc();
        sync_in[2] = 1'b0; cyc();
        ntk(5);
        chk("R7 no loss while disabled", int'(loss_state[2]), 0);
        chk("R7 no end irq on disable", end_seen[2] - e0, 0);
        chk("R7 no start irq while disabled", start_seen[2] - s0, 0);
        enable = 1'b1; cyc();
        ntk(4);
        chk("R7 old edge not acted on", int'(loss_state[2]), 0);
        sync_in[2] = 1'b1; cyc();

        // R9: go-hunt pulse
        phase = "R9";
        go_hunt[1] = 1'b1; cyc();
        chk("R9 hunt pulse", int'(force_hunt), 32'h2);
        cyc();
        chk("R9 held control no repeat", int'(force_hunt), 0);
        go_hunt[1] = 1'b0; enable = 1'b0; cyc();
        go_hunt[3] = 1'b1; cyc();
        chk("R9 hunt while disabled", int'(force_hunt), 32'h8);
        go_hunt[3] = 1'b0; enable = 1'b1; cyc();

        // R11: 50-tick persistence
        phase = "R11";
        preload = 16'd50;
        sync_in[3] = 1'b0; cyc();
        ntk(49);
        chk("R11 no loss at tick 49", int'(loss_state[3]), 0);
        tk();
        chk("R11 loss at tick 50", int'(loss_state[3]), 1);
        sync_in[3] = 1'b1; cyc();
        ntk(50);
        chk("R11 recovered after 50", int'(loss_state[3]), 0);

        // R8: random independent activity across ports
        phase = "R8";
        for (int c = 0; c < 6000; c++) begin
            for (int i = 0; i < NP; i++) begin
                if ($urandom % 30 == 0) sync_in[i] = ~sync_in[i];
                if ($urandom % 25 == 0) go_hunt[i] = ~go_hunt[i];
            end
            tick = ($urandom % 3 == 0);
            enable = ($urandom % 300 != 0);
            if ($urandom % 200 == 0) preload = TW'($urandom % 6);
            cyc();
        end
        tick = 1'b0;
        cyc();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule